// File: doc/BRIEF.md
# Boot Memory Remap Chip-Select Controller

This block turns each bus access address into one active-low chip select for the memory devices around a processor: dynamic memory, a general static bank, a second static bank for expansion, NOR flash, a disk-on-chip device and a bus-expansion port. The address space is split into 64 MB slots. Slot zero, the low window from 0x00000000 to 0x03FFFFFF, normally belongs to dynamic memory.

Out of reset the block moves a non-volatile device to slot zero so that the processor can fetch its first instructions there. Two cascaded remap flags control this. The first flag acts where the memory-controller selects are formed. It takes slot zero away from dynamic memory and gives it either to the expansion port or to static select 1. The second flag acts one level further out, on static select 1 alone. It steers that select to the disk-on-chip or the NOR device. A 2-bit boot strap picks the path through both stages. Software drops each flag by writing a one to its bit. Only reset raises a flag again.

A device smaller than 64 MB sees only the address bits it decodes, so its contents repeat through its slot. The device address output carries the access address masked to the size of the device that is selected.

Top module: `boot_remap_cs`

## Requirements
- R1: With the dynamic remap flag low, a valid access in the low window (address bits [31:26] equal to 0) asserts only `dyn_cs0_n`.
- R2: With the dynamic remap flag high, `dyn_cs0_n` stays high for every low-window access. Such an access goes to `exp_cs_n` when `boot_strap` is 2'b11, and otherwise to static select 1 before the second stage.
- R3: With the static remap flag high, every static select 1 request is steered to `doc_cs_n` for strap 2'b00 and to `nor_cs_n` for strap 2'b01. For strap 2'b10 it stays on `stat1_cs_n`. For strap 2'b11 a low-window access reaches `exp_cs_n` whatever the static flag holds.
- R4: Reset, an asynchronous active-low input, sets both remap flags high. A low-window access made right after reset therefore reaches the boot device that the strap selects.
- R5: A cycle with `flag_wr` high clears the dynamic flag when `flag_wdata[0]` is 1 and clears the static flag when `flag_wdata[1]` is 1. A data bit of 0 leaves its flag unchanged. No write can set a flag.
- R6: At most one select is low in any cycle. All selects are high while `acc_valid` is low.
- R7: `dev_addr` is the access address with every bit at or above the selected device's size cleared. Default sizes: dynamic 26 bits, static 1 24, static 2 24, NOR 25, disk-on-chip 16, expansion 26. `dev_addr` is zero when no select is active.
- R8: `stat2_cs_n` never asserts for a low-window access, under any strap or flag value.
- R9: The home slots (address bits [31:26]) are: static 1 = 9, static 2 = 10, NOR = 12, disk-on-chip = 13, expansion = 16. Every other non-zero slot asserts no select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 32 | Access byte address |
| boot_strap | input | 2 | Boot device strap |
| flag_wr | input | 1 | Flag register write strobe |
| flag_wdata | input | 2 | Write-one-to-clear: bit 0 dynamic flag, bit 1 static flag |
| dyn_cs0_n | output | 1 | Dynamic memory select 0 |
| stat1_cs_n | output | 1 | Static select 1 |
| stat2_cs_n | output | 1 | Static expansion select 2 |
| nor_cs_n | output | 1 | NOR flash select |
| doc_cs_n | output | 1 | Disk-on-chip select |
| exp_cs_n | output | 1 | Bus-expansion select |
| dev_addr | output | 32 | Address masked to the selected device's size |

## Verification
The in-RTL assertions check, on every cycle, that at most one select is low, that nothing is selected while no access is present, and that the flags never rise between resets. They also check that dynamic select 0 and static select 2 stay quiet in the low window whenever the rules say so, and that the disk-on-chip route is taken when both flags and strap 2'b00 call for it. The bench alone can show that the right device is chosen for each of the sixteen strap and flag combinations. It also checks the edges of the window and of the home slots, the width of the address aliasing for each device, and that a reset brings the cleared flags back.

// File: rtl/boot_remap_pkg.sv
package boot_remap_pkg;
   typedef enum logic [2:0] {
      SEL_NONE  = 3'd0,
      SEL_DYN0  = 3'd1,
      SEL_STAT1 = 3'd2,
      SEL_STAT2 = 3'd3,
      SEL_NOR   = 3'd4,
      SEL_DOC   = 3'd5,
      SEL_EXP   = 3'd6
   } cs_sel_e;

   localparam logic [1:0] STRAP_DOC = 2'b00;
   localparam logic [1:0] STRAP_NOR = 2'b01;
   localparam logic [1:0] STRAP_ST1 = 2'b10;
   localparam logic [1:0] STRAP_EXP = 2'b11;
endpackage

// File: rtl/remap_flag_regs.sv
module remap_flag_regs #(
   parameter int N_FLAGS = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic [N_FLAGS-1:0] wdata,
   output logic [N_FLAGS-1:0] flags
);
   if (N_FLAGS < 1) begin : g_bad_n
      $error("remap_flag_regs: N_FLAGS must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flags <= '1;
      else if (wr)  flags <= flags & ~wdata;
   end

   for (genvar i = 0; i < N_FLAGS; i++) begin : g_chk
      // R5: once cleared, a flag stays low until reset
      a_r5_no_set : assert property (@(posedge clk) disable iff (!rst_n)
         !flags[i] |=> !flags[i]);
   end
endmodule

// File: rtl/slot_decode.sv
module slot_decode
   import boot_remap_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int WIN_BITS = 26,
   localparam int SLOT_W  = ADDR_W - WIN_BITS,
   parameter logic [SLOT_W-1:0] STAT1_SLOT = SLOT_W'(9),
   parameter logic [SLOT_W-1:0] STAT2_SLOT = SLOT_W'(10),
   parameter logic [SLOT_W-1:0] NOR_SLOT   = SLOT_W'(12),
   parameter logic [SLOT_W-1:0] DOC_SLOT   = SLOT_W'(13),
   parameter logic [SLOT_W-1:0] EXP_SLOT   = SLOT_W'(16)
) (
   input  logic              valid,
   input  logic [ADDR_W-1:0] addr,
   input  logic              dyn_remap,
   input  logic [1:0]        strap,
   output cs_sel_e           chip_sel
);
   if (SLOT_W < 1) begin : g_bad_w
      $error("slot_decode: WIN_BITS must be below ADDR_W");
   end
   if (STAT1_SLOT == 0 || STAT2_SLOT == 0 || NOR_SLOT == 0 ||
       DOC_SLOT == 0 || EXP_SLOT == 0) begin : g_bad_slot
      $error("slot_decode: slot zero is reserved for the boot window");
   end

   logic [SLOT_W-1:0] slot;
   assign slot = addr[ADDR_W-1:WIN_BITS];

   always_comb begin
      chip_sel = SEL_NONE;
      if (valid) begin
         if (slot == '0) begin
            if (!dyn_remap)              chip_sel = SEL_DYN0;
            else if (strap == STRAP_EXP) chip_sel = SEL_EXP;
            else                         chip_sel = SEL_STAT1;
         end
         else if (slot == STAT1_SLOT) chip_sel = SEL_STAT1;
         else if (slot == STAT2_SLOT) chip_sel = SEL_STAT2;
         else if (slot == NOR_SLOT)   chip_sel = SEL_NOR;
         else if (slot == DOC_SLOT)   chip_sel = SEL_DOC;
         else if (slot == EXP_SLOT)   chip_sel = SEL_EXP;
      end
   end
endmodule

// File: rtl/static_reroute.sv
module static_reroute
   import boot_remap_pkg::*;
#(
   parameter bit STAGE2_EN = 1'b1
) (
   input  cs_sel_e    chip_sel,
   input  logic       stat_remap,
   input  logic [1:0] strap,
   output cs_sel_e    board_sel
);
   if (STAGE2_EN) begin : g_stage2
      always_comb begin
         board_sel = chip_sel;
         if (stat_remap && chip_sel == SEL_STAT1) begin
            case (strap)
               STRAP_DOC: board_sel = SEL_DOC;
               STRAP_NOR: board_sel = SEL_NOR;
               default:   board_sel = SEL_STAT1;
            endcase
         end
      end
   end else begin : g_bypass
      logic unused_ok;
      assign unused_ok = stat_remap ^ (^strap);
      assign board_sel = chip_sel;
   end
endmodule

// File: rtl/addr_alias.sv
module addr_alias
   import boot_remap_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int WIN_BITS  = 26,
   parameter int DYN_BITS  = 26,
   parameter int STAT1_BITS = 24,
   parameter int STAT2_BITS = 24,
   parameter int NOR_BITS  = 25,
   parameter int DOC_BITS  = 16,
   parameter int EXP_BITS  = 26
) (
   input  cs_sel_e           sel,
   input  logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] dev_addr
);
   localparam int N_DEV = 6;
   localparam int DEV_BITS [N_DEV] = '{DYN_BITS, STAT1_BITS, STAT2_BITS,
                                       NOR_BITS, DOC_BITS, EXP_BITS};

   logic [ADDR_W-1:0] mask [N_DEV];

   for (genvar d = 0; d < N_DEV; d++) begin : g_mask
      if (DEV_BITS[d] < 1 || DEV_BITS[d] > WIN_BITS) begin : g_bad
         $error("addr_alias: device size must lie in 1..WIN_BITS");
      end
      assign mask[d] = ADDR_W'((64'd1 << DEV_BITS[d]) - 64'd1);
   end

   always_comb begin
      case (sel)
         SEL_DYN0:  dev_addr = addr & mask[0];
         SEL_STAT1: dev_addr = addr & mask[1];
         SEL_STAT2: dev_addr = addr & mask[2];
         SEL_NOR:   dev_addr = addr & mask[3];
         SEL_DOC:   dev_addr = addr & mask[4];
         SEL_EXP:   dev_addr = addr & mask[5];
         default:   dev_addr = '0;
      endcase
   end
endmodule

// File: rtl/boot_remap_cs.sv
module boot_remap_cs
   import boot_remap_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int WIN_BITS   = 26,
   parameter bit STAGE2_EN  = 1'b1,
   parameter int DYN_BITS   = 26,
   parameter int STAT1_BITS = 24,
   parameter int STAT2_BITS = 24,
   parameter int NOR_BITS   = 25,
   parameter int DOC_BITS   = 16,
   parameter int EXP_BITS   = 26
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [1:0]        boot_strap,
   input  logic              flag_wr,
   input  logic [1:0]        flag_wdata,
   output logic              dyn_cs0_n,
   output logic              stat1_cs_n,
   output logic              stat2_cs_n,
   output logic              nor_cs_n,
   output logic              doc_cs_n,
   output logic              exp_cs_n,
   output logic [ADDR_W-1:0] dev_addr
);
   logic [1:0] flags;
   cs_sel_e    chip_sel;
   cs_sel_e    board_sel;

   remap_flag_regs #(.N_FLAGS(2)) u_flags (
      .clk(clk), .rst_n(rst_n), .wr(flag_wr), .wdata(flag_wdata), .flags(flags)
   );

   slot_decode #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_stage1 (
      .valid(acc_valid), .addr(acc_addr), .dyn_remap(flags[0]),
      .strap(boot_strap), .chip_sel(chip_sel)
   );

   static_reroute #(.STAGE2_EN(STAGE2_EN)) u_stage2 (
      .chip_sel(chip_sel), .stat_remap(flags[1]), .strap(boot_strap),
      .board_sel(board_sel)
   );

   addr_alias #(
      .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .DYN_BITS(DYN_BITS),
      .STAT1_BITS(STAT1_BITS), .STAT2_BITS(STAT2_BITS), .NOR_BITS(NOR_BITS),
      .DOC_BITS(DOC_BITS), .EXP_BITS(EXP_BITS)
   ) u_alias (
      .sel(board_sel), .addr(acc_addr), .dev_addr(dev_addr)
   );

   assign dyn_cs0_n  = (board_sel != SEL_DYN0);
   assign stat1_cs_n = (board_sel != SEL_STAT1);
   assign stat2_cs_n = (board_sel != SEL_STAT2);
   assign nor_cs_n   = (board_sel != SEL_NOR);
   assign doc_cs_n   = (board_sel != SEL_DOC);
   assign exp_cs_n   = (board_sel != SEL_EXP);

   logic low_win;
   assign low_win = acc_valid && (acc_addr[ADDR_W-1:WIN_BITS] == '0);

   // R6: never two devices at once
   a_r6_one_select : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~{dyn_cs0_n, stat1_cs_n, stat2_cs_n, nor_cs_n, doc_cs_n, exp_cs_n}));
   // R6: quiet bus without an access
   a_r6_idle_high : assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> &{dyn_cs0_n, stat1_cs_n, stat2_cs_n, nor_cs_n, doc_cs_n, exp_cs_n});
   // R2: dynamic memory leaves the low window while the first flag is up
   a_r2_no_dyn_boot : assert property (@(posedge clk) disable iff (!rst_n)
      (low_win && flags[0]) |-> dyn_cs0_n);
   // R8: the expansion static bank is never a boot device
   a_r8_no_stat2_boot : assert property (@(posedge clk) disable iff (!rst_n)
      low_win |-> stat2_cs_n);
   // R3: disk-on-chip boot route
   a_r3_doc_route : assert property (@(posedge clk) disable iff (!rst_n)
      (STAGE2_EN && low_win && flags == 2'b11 && boot_strap == STRAP_DOC) |-> !doc_cs_n);
endmodule

// File: tb/test_boot_remap_cs.sv
module test_boot_remap_cs;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_addr = '0;
   logic [1:0]  boot_strap = 2'b00;
   logic        flag_wr = 1'b0;
   logic [1:0]  flag_wdata = 2'b00;
   logic        dyn_cs0_n, stat1_cs_n, stat2_cs_n, nor_cs_n, doc_cs_n, exp_cs_n;
   logic [31:0] dev_addr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [1:0] mf = 2'b11;   // model flags: bit0 dynamic, bit1 static

   always #(CLK_P/2) clk = ~clk;

   boot_remap_cs i_boot_remap_cs (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
      .boot_strap(boot_strap), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
      .dyn_cs0_n(dyn_cs0_n), .stat1_cs_n(stat1_cs_n), .stat2_cs_n(stat2_cs_n),
      .nor_cs_n(nor_cs_n), .doc_cs_n(doc_cs_n), .exp_cs_n(exp_cs_n),
      .dev_addr(dev_addr)
   );

   // device index: 0 none, 1 dyn, 2 stat1, 3 stat2, 4 nor, 5 doc, 6 exp
   function automatic int ref_dev(bit v, logic [31:0] a, logic [1:0] s, logic [1:0] f);
      int slot = int'(a[31:26]);
      if (!v) return 0;
      if (slot == 0) begin
         if (!f[0]) return 1;
         if (s == 2'b11) return 6;
         if (f[1] && s == 2'b00) return 5;
         if (f[1] && s == 2'b01) return 4;
         return 2;
      end
      if (slot == 9) begin
         if (f[1] && s == 2'b00) return 5;
         if (f[1] && s == 2'b01) return 4;
         return 2;
      end
      if (slot == 10) return 3;
      if (slot == 12) return 4;
      if (slot == 13) return 5;
      if (slot == 16) return 6;
      return 0;
   endfunction

   function automatic logic [5:0] sel_bits(int d);
      logic [5:0] r = 6'h3F;   // {dyn, stat1, stat2, nor, doc, exp}, active low
      if (d >= 1) r[6-d] = 1'b0;
      return r;
   endfunction

   function automatic logic [31:0] ref_addr(int d, logic [31:0] a);
      int bits;
      case (d)
         1: bits = 26; 2: bits = 24; 3: bits = 24;
         4: bits = 25; 5: bits = 16; 6: bits = 26;
         default: return 32'h0;
      endcase
      return a & 32'((64'd1 << bits) - 64'd1);
   endfunction

   task automatic check(string req, logic [63:0] act, logic [63:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic step(bit v, logic [31:0] a, logic [1:0] s, bit wr, logic [1:0] wd);
      int d;
      logic [5:0] got;
      string tag;
      @(negedge clk);
      acc_valid = v; acc_addr = a; boot_strap = s; flag_wr = wr; flag_wdata = wd;
      #(CLK_P/4);
      d = ref_dev(v, a, s, mf);
      got = {dyn_cs0_n, stat1_cs_n, stat2_cs_n, nor_cs_n, doc_cs_n, exp_cs_n};
      if (!v) tag = "R6";
      else if (a[31:26] != 0) tag = (a[31:26] == 6'd9 && mf[1]) ? "R3" : "R9";
      else if (!mf[0]) tag = "R1";
      else if (mf[1] && s != 2'b11) tag = "R3";
      else tag = "R2";
      check(tag, 64'(got), 64'(sel_bits(d)));
      check("R7", 64'(dev_addr), 64'(ref_addr(d, a)));
      check("R6", 64'($countones(~got) <= 1), 64'd1);
      if (v && a[31:26] == 0) check("R8", 64'(stat2_cs_n), 64'd1);
      @(posedge clk);
      if (wr) mf = mf & ~wd;
   endtask

   task automatic do_reset(logic [1:0] s);
      @(negedge clk);
      rst_n = 1'b0; acc_valid = 1'b1; acc_addr = 32'h0000_0040; boot_strap = s;
      flag_wr = 1'b0; flag_wdata = 2'b00;
      mf = 2'b11;
      #(CLK_P/4);
      // R4: in reset both flags are high, so the boot device answers at zero
      check("R4", 64'({dyn_cs0_n, stat1_cs_n, stat2_cs_n, nor_cs_n, doc_cs_n, exp_cs_n}),
            64'(sel_bits(ref_dev(1'b1, 32'h40, s, 2'b11))));
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      logic [31:0] pts [16];
      pts = '{32'h0000_0000, 32'h0000_1234, 32'h03FF_FFFF, 32'h0400_0000,
              32'h23FF_FFFF, 32'h2400_0000, 32'h27FF_FFFF, 32'h2800_0000,
              32'h2BFF_FFFF, 32'h3000_0000, 32'h33FF_FFFF, 32'h3401_FFFF,
              32'h37FF_FFFF, 32'h4000_0000, 32'h43FF_FFFF, 32'hFFFF_FFFF};
      for (int s = 0; s < 4; s++) begin
         for (int c = 0; c < 4; c++) begin
            do_reset(2'(s));
            // R5: writing zero leaves the flags alone
            step(1'b1, 32'h0000_0100, 2'(s), 1'b1, 2'b00);
            // R5: write-one-to-clear the flags not kept in combination c
            step(1'b0, 32'h0, 2'(s), 1'b1, ~2'(c));
            for (int p = 0; p < 16; p++) step(1'b1, pts[p], 2'(s), 1'b0, 2'b00);
            step(1'b0, 32'h0000_0000, 2'(s), 1'b0, 2'b00);
            step(1'b0, 32'h2400_0000, 2'(s), 1'b0, 2'b00);
         end
      end
      // R5: a write of ones never sets a cleared flag back
      do_reset(2'b00);
      step(1'b1, 32'h0, 2'b00, 1'b1, 2'b11);
      step(1'b1, 32'h0, 2'b00, 1'b1, 2'b11);
      check("R5", 64'(dyn_cs0_n), 64'd0);
      step(1'b1, 32'h0300_0004, 2'b00, 1'b0, 2'b00);
      // R4: reset brings the boot device back
      do_reset(2'b01);
      step(1'b1, 32'h01FF_FFFC, 2'b01, 1'b0, 2'b00);
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule